// File: doc/BRIEF.md
# Bit-Slice Add/Subtract and Logic Unit

This block is a purely combinational arithmetic/logic unit assembled from a row of identical one-bit slices. Each slice contains a full adder and a four-input result selector. The carry leaves each slice and enters the slice above it, so the sum ripples from bit 0 to the top bit. A two-level opcode selects the operation. One control bit chooses between adding and subtracting. A two-bit function code chooses the arithmetic result, the complement of the second operand, the bitwise OR or the bitwise AND.

Beside the result word, the unit gives two flags. The first reports two's-complement overflow from the arithmetic path. The second goes high whenever any bit of the result is set. The block has no clock and holds no state, so every output follows its inputs within the same cycle. The operand width is a parameter and defaults to 32 bits.

Top module: `slice_alu`

## Requirements
- R1: With function code 0 and the subtract bit 0, the result equals the sum of the two operands modulo 2^WIDTH.
- R2: With function code 0 and the subtract bit 1, the result equals operand A minus operand B modulo 2^WIDTH. This is done by inverting B into every slice and forcing a carry of 1 into slice 0.
- R3: With function code 1, the result is the bitwise complement of operand B, whatever the value of the subtract bit.
- R4: With function code 2, the result is the bitwise OR of the two operands.
- R5: With function code 3, the result is the bitwise AND of the two operands.
- R6: With function code 0 and the subtract bit 0, the overflow flag is 1 exactly when the signed sum falls outside the signed WIDTH-bit range. This is the XOR of the carry into and out of the top slice.
- R7: With function code 0 and the subtract bit 1, the overflow flag is 1 exactly when the signed difference falls outside the signed WIDTH-bit range.
- R8: With function codes 1, 2 and 3, the overflow flag is 0.
- R9: The non-zero flag is 1 exactly when at least one result bit is 1, for every function code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sub_i | input | 1 | 0 = add, 1 = subtract (function code 0 only) |
| func_i | input | 2 | Function code: 0 arithmetic, 1 NOT B, 2 OR, 3 AND |
| res_o | output | WIDTH | Result word |
| ovf_o | output | 1 | Signed overflow of the arithmetic path |
| nz_o | output | 1 | Result is non-zero |

## Verification
All three outputs are combinational, so each result is due in the same cycle as the operands that produce it, with zero registers on the path. The bench changes the inputs just after a rising edge and reads all outputs at the following falling edge. The ripple chain has therefore settled, and no value from an earlier vector can still be present. A 4-bit copy of the unit is swept over every operand pair, subtract value and function code. A 32-bit copy is driven with corner operands (zero, one, all ones, the most negative and most positive values, alternating patterns) and with pseudo-random words.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        FN_ARITH = 2'd0,
        FN_NOTB  = 2'd1,
        FN_OR    = 2'd2,
        FN_AND   = 2'd3
    } func_e;

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic  a_i,
    input  logic  b_i,
    input  logic  sub_i,
    input  func_e func_i,
    input  logic  cin_i,
    output logic  cout_o,
    output logic  res_o
);
    logic b_eff;
    logic sum;

    // Full adder; B is inverted on subtraction.
    always_comb begin
        b_eff  = b_i ^ sub_i;
        sum    = a_i ^ b_eff ^ cin_i;
        cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
    end

    // Four-way result selector.
    always_comb begin
        unique case (func_i)
            FN_ARITH: res_o = sum;
            FN_NOTB:  res_o = ~b_i;
            FN_OR:    res_o = a_i | b_i;
            FN_AND:   res_o = a_i & b_i;
        endcase
    end
endmodule

// File: rtl/alu_slice_chain.sv
module alu_slice_chain
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    input  func_e            func_i,
    output logic [WIDTH-1:0] res_o,
    output logic             c_msb_in_o,
    output logic             c_msb_out_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] carry;

    // Subtraction needs +1 on top of the inverted B.
    assign carry[0] = sub_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_bit_slice i_slice (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .sub_i  (sub_i),
            .func_i (func_i),
            .cin_i  (carry[i]),
            .cout_o (carry[i+1]),
            .res_o  (res_o[i])
        );
    end

    assign c_msb_in_o  = carry[MSB];
    assign c_msb_out_o = carry[WIDTH];
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res_i,
    input  func_e            func_i,
    input  logic             c_msb_in_i,
    input  logic             c_msb_out_i,
    output logic             ovf_o,
    output logic             nz_o
);
    always_comb begin
        unique case (func_i)
            FN_ARITH: ovf_o = c_msb_in_i ^ c_msb_out_i;
            default:  ovf_o = 1'b0;
        endcase
        nz_o = |res_i;
    end
endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    input  logic [1:0]       func_i,
    output logic [WIDTH-1:0] res_o,
    output logic             ovf_o,
    output logic             nz_o
);
    func_e func;
    logic  c_msb_in;
    logic  c_msb_out;

    assign func = func_e'(func_i);

    alu_slice_chain #(.WIDTH(WIDTH)) i_chain (
        .a_i         (a_i),
        .b_i         (b_i),
        .sub_i       (sub_i),
        .func_i      (func),
        .res_o       (res_o),
        .c_msb_in_o  (c_msb_in),
        .c_msb_out_o (c_msb_out)
    );

    alu_flag_unit #(.WIDTH(WIDTH)) i_flags (
        .res_i       (res_o),
        .func_i      (func),
        .c_msb_in_i  (c_msb_in),
        .c_msb_out_i (c_msb_out),
        .ovf_o       (ovf_o),
        .nz_o        (nz_o)
    );
endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             sub_i,
    input logic [1:0]       func_i,
    input logic [WIDTH-1:0] res_o,
    input logic             ovf_o,
    input logic             nz_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] sum_ref;
    logic [WIDTH-1:0] diff_ref;

    always_comb begin
        sum_ref  = a_i + b_i;
        diff_ref = a_i - b_i;
        if (func_i == 2'd0 && !sub_i)
            AST_ADD_SUM: assert (res_o == sum_ref) else $error("add result"); // R1
        if (func_i == 2'd0 && sub_i)
            AST_SUB_DIFF: assert (res_o == diff_ref) else $error("sub result"); // R2
        if (func_i == 2'd1)
            AST_NOT_B: assert (res_o == ~b_i) else $error("not-b result"); // R3
        if (func_i == 2'd2)
            AST_OR_RES: assert (res_o == (a_i | b_i)) else $error("or result"); // R4
        if (func_i == 2'd3)
            AST_AND_RES: assert (res_o == (a_i & b_i)) else $error("and result"); // R5
        if (func_i == 2'd0 && !sub_i)
            AST_ADD_OVERFLOW: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB]))) else $error("add ovf"); // R6
        if (func_i == 2'd0 && sub_i)
            AST_SUB_OVERFLOW: assert (ovf_o == ((a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB]))) else $error("sub ovf"); // R7
        if (func_i != 2'd0)
            AST_NO_OVERFLOW: assert (!ovf_o) else $error("logic ovf"); // R8
        AST_NONZERO: assert (nz_o == (res_o != '0)) else $error("nz flag"); // R9
    end
endmodule

bind slice_alu slice_alu_chk #(.WIDTH(WIDTH)) i_slice_alu_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub_i),
    .func_i (func_i),
    .res_o  (res_o),
    .ovf_o  (ovf_o),
    .nz_o   (nz_o)
);

// File: tb/test_slice_alu.sv
module test_slice_alu;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // 4-bit copy for exhaustive sweep
    logic [3:0]  n_a, n_b, n_res;
    logic        n_sub, n_ovf, n_nz;
    logic [1:0]  n_fn;
    // 32-bit copy for corner and random operands
    logic [31:0] w_a, w_b, w_res;
    logic        w_sub, w_ovf, w_nz;
    logic [1:0]  w_fn;

    slice_alu #(.WIDTH(4)) i_slice_alu (
        .a_i(n_a), .b_i(n_b), .sub_i(n_sub), .func_i(n_fn),
        .res_o(n_res), .ovf_o(n_ovf), .nz_o(n_nz)
    );

    slice_alu #(.WIDTH(32)) i_slice_alu_wide (
        .a_i(w_a), .b_i(w_b), .sub_i(w_sub), .func_i(w_fn),
        .res_o(w_res), .ovf_o(w_ovf), .nz_o(w_nz)
    );

    // Arithmetic reference built from signed integer ranges.
    task automatic expect_of(input int w, input logic [31:0] a, input logic [31:0] b,
                             input logic sub, input logic [1:0] fn,
                             output logic [31:0] r, output logic ov, output logic nz);
        longint mask, sa, sb, tv, hi, lo;
        mask = (longint'(1) <<< w) - 1;
        hi   = (longint'(1) <<< (w - 1)) - 1;
        lo   = -(longint'(1) <<< (w - 1));
        sa   = longint'(a) & mask;
        sb   = longint'(b) & mask;
        if (sa > hi) sa = sa - (mask + 1);
        if (sb > hi) sb = sb - (mask + 1);
        ov = 1'b0;
        case (fn)
            2'd0: begin
                tv = sub ? sa - sb : sa + sb;
                ov = (tv > hi) || (tv < lo);
                r  = 32'(tv & mask);
            end
            2'd1: r = 32'((~longint'(b)) & mask);
            2'd2: r = a | b;
            default: r = a & b;
        endcase
        nz = (r != 32'd0);
    endtask

    task automatic compare(input int w, input logic [31:0] a, input logic [31:0] b,
                           input logic sub, input logic [1:0] fn,
                           input logic [31:0] gr, input logic gov, input logic gnz);
        logic [31:0] er;
        logic eov, enz;
        string rtag, otag;
        expect_of(w, a, b, sub, fn, er, eov, enz);
        case (fn)
            2'd0: begin rtag = sub ? "R2" : "R1"; otag = sub ? "R7" : "R6"; end
            2'd1: begin rtag = "R3"; otag = "R8"; end
            2'd2: begin rtag = "R4"; otag = "R8"; end
            default: begin rtag = "R5"; otag = "R8"; end
        endcase
        checks++;
        if (gr != er) begin
            fails++;
            $display("FAIL %s w=%0d a=%h b=%h sub=%b fn=%0d result actual=%h expected=%h",
                     rtag, w, a, b, sub, fn, gr, er);
        end
        checks++;
        if (gov != eov) begin
            fails++;
            $display("FAIL %s w=%0d a=%h b=%h sub=%b fn=%0d ovf actual=%b expected=%b",
                     otag, w, a, b, sub, fn, gov, eov);
        end
        checks++;
        if (gnz != enz) begin
            fails++;
            $display("FAIL R9 w=%0d a=%h b=%h fn=%0d nz actual=%b expected=%b",
                     w, a, b, fn, gnz, enz);
        end
    endtask

    task automatic apply_wide(input logic [31:0] a, input logic [31:0] b);
        for (int s = 0; s < 2; s++) begin
            for (int f = 0; f < 4; f++) begin
                @(posedge clk);
                w_a = a; w_b = b; w_sub = s[0]; w_fn = f[1:0];
                @(negedge clk);
                compare(32, w_a, w_b, w_sub, w_fn, w_res, w_ovf, w_nz);
            end
        end
    endtask

    initial begin
        logic [31:0] corner [7];
        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
        corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h8000_0000;
        corner[4] = 32'h7FFF_FFFF; corner[5] = 32'hAAAA_AAAA;
        corner[6] = 32'h5555_5555;
        n_a = '0; n_b = '0; n_sub = 1'b0; n_fn = 2'd0;
        w_a = '0; w_b = '0; w_sub = 1'b0; w_fn = 2'd0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle inputs: zero result, both flags low (R9, R6)
        compare(4, 32'(n_a), 32'(n_b), n_sub, n_fn, 32'(n_res), n_ovf, n_nz);
        compare(32, w_a, w_b, w_sub, w_fn, w_res, w_ovf, w_nz);

        // Exhaustive 4-bit sweep: R1..R9, subtract bit toggled under every code (R3)
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int f = 0; f < 4; f++) begin
                        @(posedge clk);
                        n_a = a[3:0]; n_b = b[3:0]; n_sub = s[0]; n_fn = f[1:0];
                        @(negedge clk);
                        compare(4, 32'(n_a), 32'(n_b), n_sub, n_fn, 32'(n_res), n_ovf, n_nz);
                    end
                end
            end
        end

        // 32-bit corner pairs, including most negative and -1
        for (int i = 0; i < 7; i++)
            for (int j = 0; j < 7; j++)
                apply_wide(corner[i], corner[j]);

        // 32-bit pseudo-random operands
        for (int k = 0; k < 150; k++)
            apply_wide($urandom, $urandom);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before the sweep completed");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule